// File: doc/BRIEF.md
# Line-Rate Paced Frame Sink with Start-of-Frame Timestamp

This block is the receiving end of a streaming interface that carries outgoing Ethernet frames. It accepts beats only as fast as a real link of a chosen speed could put them on the wire. The link speed is a fixed-point byte credit that is added on every clock. Before a frame's payload is accepted, the block waits out eight byte-times of preamble. At the moment the start-of-frame delimiter would go out, it latches the free-running 96-bit precision time and presents it with a one-cycle strobe. After the last beat of a frame it holds off for a programmable inter-frame gap. It also reports the byte length of each frame, and it flags beats that the source failed to supply in time.

Four states form the control. IDLE clears the credit and waits for a valid beat. The IDLE→PREAMBLE transition fires on the first edge with valid high. PREAMBLE→DATA fires on the edge that spends eight bytes of credit, and that edge also captures the timestamp. DATA→GAP fires on the edge that accepts the beat marked last. GAP→IDLE fires on the edge that spends the gap's byte-times of credit. Physical encoding, CRC handling and frame storage belong elsewhere.

Top module: `line_pace_sink`

## Requirements
- R1: While `rst` is high, `s_tready`, `ts_valid`, `frm_done` and `underflow` are low and `ts_out` is zero, even when a timestamp was held before reset.
- R2: `s_tready` is never high in IDLE, PREAMBLE or GAP. In DATA it is high exactly when the credit covers one full beat of DATA_W/8 bytes. At 2 bytes per clock, the first beat is accepted 4 edges after the timestamp edge.
- R3: The credit grows by INC_Q/2^FRAC_W bytes per clock. It is zero after every IDLE cycle and never exceeds max(DATA_W/8, 8, GAP_BYTES) bytes. At 2 bytes per clock, back-to-back full 8-byte beats are accepted 4 edges apart.
- R4: A frame is detected on the first edge in IDLE with `s_tvalid` high. From zero, eight byte-times of credit must accrue, and the edge that spends them ends the preamble. At 2 bytes per clock, that edge comes 5 edges after detection.
- R5: On the edge that ends the preamble, `ts_out` loads the value of `ptp_now` sampled at that edge. `ts_valid` is high for exactly one cycle, once per frame.
- R6: An accepted beat spends as many bytes of credit as `s_tkeep` has set bits. Bit i marks byte lane i (data bits 8i+7..8i), and the set bits need not be contiguous. DATA_W must be a multiple of 8.
- R7: `frm_done` is high for one cycle, right after the edge that accepts the beat with `s_tlast` high. At the same time `frm_len` shows the total count of set `s_tkeep` bits over the frame.
- R8: After the last beat, GAP_BYTES byte-times of credit are spent before IDLE is re-entered, and credit left over from a short last beat counts toward them. At 2 bytes per clock with GAP_BYTES=12 and the next frame waiting: a full last beat puts the next timestamp 12 edges after the last accept, and a 4-byte last beat puts it 10 edges after.
- R9: `underflow` is high in the cycle after each edge in DATA where the credit covers a beat but `s_tvalid` is low. It stays low for frames supplied without pauses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tkeep | input | DATA_W/8 | Byte-lane enables of the beat |
| s_tlast | input | 1 | Beat closes the frame |
| s_tvalid | input | 1 | Beat offered |
| s_tready | output | 1 | Beat taken on this edge if valid |
| ptp_now | input | TS_W | Free-running precision time |
| ts_out | output | TS_W | Time captured at the delimiter instant |
| ts_valid | output | 1 | One-cycle strobe for `ts_out` |
| frm_len | output | LEN_W | Byte count of the finished frame |
| frm_done | output | 1 | One-cycle strobe for `frm_len` |
| underflow | output | 1 | Source ran dry in mid-frame |

## Verification
The bench targets the exact edge counts of each paced interval. If the credit were not cleared in IDLE, the preamble would be too short. If a partial beat were charged a full beat, the spacing after it would be 4 edges instead of 2. If leftover credit were dropped at the start of the gap, the next timestamp after a short last beat would come 12 edges late rather than 10. Frames with sparse lane enables would expose a length counter that counts beats or the highest lane instead of set bits. A stall in mid-frame must raise `underflow`, and a reset that fails to wipe a held timestamp would leave a stale value on `ts_out`.

// File: rtl/pace_pkg.sv
`timescale 1ns/1ps
package pace_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_DATA,
        ST_GAP
    } pace_state_e;

    localparam int LANE_BITS      = 8;
    localparam int PREAMBLE_BYTES = 8;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pace_credit.sv
`timescale 1ns/1ps
// Fixed-point byte credit: grows by INC_Q per clock, saturates at MAX_Q,
// is cleared on request and reduced by what the controller spends.
module pace_credit #(
    parameter int CW    = 14,
    parameter int INC_Q = 2048,
    parameter int MAX_Q = 3072
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [CW-1:0] spend,
    output logic [CW-1:0] credit
);
    logic [CW:0]   gross;
    logic [CW-1:0] credit_d;

    always_comb begin
        gross = {1'b0, credit} - {1'b0, spend} + (CW+1)'(INC_Q);
        if (gross > (CW+1)'(MAX_Q))
            credit_d = CW'(MAX_Q);
        else
            credit_d = gross[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            credit <= '0;
        else
            credit <= credit_d;
    end

    // R3
    credit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        credit <= CW'(MAX_Q))
        else $error("credit above ceiling");

    // R3
    no_overdraft_chk: assert property (@(posedge clk) disable iff (rst)
        spend <= credit)
        else $error("spend exceeds available credit");

endmodule

// File: rtl/pace_len.sv
`timescale 1ns/1ps
// Per-beat lane count and per-frame byte total.
module pace_len #(
    parameter int LANES = 8,
    parameter int NB_W  = 4,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] keep,
    input  logic             accept,
    input  logic             last,
    output logic [NB_W-1:0]  beat_bytes,
    output logic [LEN_W-1:0] frm_len,
    output logic             frm_done
);
    logic [LEN_W-1:0] run_q;
    logic [LEN_W-1:0] run_sum;

    always_comb begin
        beat_bytes = '0;
        for (int i = 0; i < LANES; i++)
            beat_bytes = beat_bytes + NB_W'(keep[i]);
    end

    assign run_sum = run_q + LEN_W'(beat_bytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            frm_len  <= '0;
            frm_done <= 1'b0;
        end else begin
            frm_done <= 1'b0;
            if (accept) begin
                if (last) begin
                    frm_len  <= run_sum;
                    frm_done <= 1'b1;
                    run_q    <= '0;
                end else begin
                    run_q    <= run_sum;
                end
            end
        end
    end

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        frm_done |-> $past(accept && last))
        else $error("length strobe without a closing beat");

endmodule

// File: rtl/pace_stamp.sv
`timescale 1ns/1ps
// Holds the precision time captured at the delimiter instant.
module pace_stamp #(
    parameter int TS_W = 96
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [TS_W-1:0] ptp_now,
    output logic [TS_W-1:0] ts_out,
    output logic            ts_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ts_out   <= '0;
            ts_valid <= 1'b0;
        end else begin
            ts_valid <= capture;
            if (capture)
                ts_out <= ptp_now;
        end
    end

    // R5
    stamp_value_chk: assert property (@(posedge clk) disable iff (rst)
        ts_valid |-> ts_out == $past(ptp_now))
        else $error("timestamp does not match sampled time");

    // R5
    stamp_single_chk: assert property (@(posedge clk) disable iff (rst)
        ts_valid |=> !ts_valid)
        else $error("timestamp strobe longer than one cycle");

endmodule

// File: rtl/line_pace_sink.sv
`timescale 1ns/1ps
module line_pace_sink
    import pace_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int GAP_BYTES = 12,
    parameter int FRAC_W    = 8,
    parameter int INC_Q     = 2048,
    parameter int LEN_W     = 16,
    parameter int TS_W      = 96
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DATA_W/LANE_BITS-1:0] s_tkeep,
    input  logic                       s_tlast,
    input  logic                       s_tvalid,
    output logic                       s_tready,
    input  logic [TS_W-1:0]            ptp_now,
    output logic [TS_W-1:0]            ts_out,
    output logic                       ts_valid,
    output logic [LEN_W-1:0]           frm_len,
    output logic                       frm_done,
    output logic                       underflow
);
    localparam int LANES  = DATA_W / LANE_BITS;
    localparam int NB_W   = $clog2(LANES + 1);
    localparam int BEAT_Q = LANES << FRAC_W;
    localparam int PRE_Q  = PREAMBLE_BYTES << FRAC_W;
    localparam int GAP_Q  = GAP_BYTES << FRAC_W;
    localparam int MAX_B  = max3(LANES, PREAMBLE_BYTES, GAP_BYTES);
    localparam int MAX_Q  = MAX_B << FRAC_W;
    localparam int CW     = $clog2(MAX_Q + INC_Q + 1) + 1;

    pace_state_e     state_q, state_d;
    logic [CW-1:0]   credit;
    logic [CW-1:0]   spend;
    logic [NB_W-1:0] beat_bytes;
    logic            beat_ok, pre_done, gap_done;
    logic            accept, clear_credit, capture, dry;

    assign beat_ok  = credit >= CW'(BEAT_Q);
    assign pre_done = credit >= CW'(PRE_Q);
    assign gap_done = credit >= CW'(GAP_Q);
    assign accept   = s_tvalid && s_tready;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (s_tvalid)           state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (pre_done)           state_d = ST_DATA;
            ST_DATA:     if (accept && s_tlast)  state_d = ST_GAP;
            ST_GAP:      if (gap_done)           state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // outputs and credit spending
    always_comb begin
        s_tready     = 1'b0;
        spend        = '0;
        capture      = 1'b0;
        clear_credit = 1'b0;
        dry          = 1'b0;
        unique case (state_q)
            ST_IDLE: clear_credit = 1'b1;
            ST_PREAMBLE: begin
                if (pre_done) begin
                    spend   = CW'(PRE_Q);
                    capture = 1'b1;
                end
            end
            ST_DATA: begin
                s_tready = beat_ok;
                if (beat_ok && s_tvalid)
                    spend = CW'(beat_bytes) << FRAC_W;
                dry = beat_ok && !s_tvalid;
            end
            ST_GAP: begin
                if (gap_done)
                    spend = CW'(GAP_Q);
            end
            default: clear_credit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            underflow <= 1'b0;
        else
            underflow <= dry;
    end

    pace_credit #(
        .CW    (CW),
        .INC_Q (INC_Q),
        .MAX_Q (MAX_Q)
    ) i_credit (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear_credit),
        .spend  (spend),
        .credit (credit)
    );

    pace_len #(
        .LANES (LANES),
        .NB_W  (NB_W),
        .LEN_W (LEN_W)
    ) i_len (
        .clk        (clk),
        .rst        (rst),
        .keep       (s_tkeep),
        .accept     (accept),
        .last       (s_tlast),
        .beat_bytes (beat_bytes),
        .frm_len    (frm_len),
        .frm_done   (frm_done)
    );

    pace_stamp #(
        .TS_W (TS_W)
    ) i_stamp (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .ptp_now  (ptp_now),
        .ts_out   (ts_out),
        .ts_valid (ts_valid)
    );

    // R6
    initial begin : lane_width_chk
        assert (DATA_W % LANE_BITS == 0)
            else $error("data width is not a whole number of byte lanes");
    end

    // R5
    stamp_in_data_chk: assert property (@(posedge clk) disable iff (rst)
        ts_valid |-> state_q == ST_DATA)
        else $error("timestamp strobe outside payload state");

    // R8
    last_to_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready && s_tlast) |=> state_q == ST_GAP)
        else $error("closing beat did not start the gap");

    // R7
    done_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
        frm_done |-> state_q == ST_GAP)
        else $error("length strobe outside gap");

    // R9
    underflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> $past(state_q == ST_DATA && !s_tvalid))
        else $error("underflow without a dry payload cycle");

endmodule

// File: tb/test_line_pace_sink.sv
`timescale 1ns/1ps
module test_line_pace_sink;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 64;
    localparam int LANES      = DATA_W / 8;
    localparam int GAP_BYTES  = 12;
    localparam int FRAC_W     = 8;
    localparam int INC_Q      = 512;   // 2 bytes per clock
    localparam int LEN_W      = 16;
    localparam int TS_W       = 96;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] tkeep = '0;
    logic             tlast = 1'b0;
    logic             tvalid = 1'b0;
    logic             tready;
    logic [TS_W-1:0]  ptp;
    logic [TS_W-1:0]  ts;
    logic             tsv;
    logic [LEN_W-1:0] flen;
    logic             fdone;
    logic             uflow;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int ts_cnt = 0;
    int ts_edge [64];
    int done_cnt = 0;
    int done_edge [64];
    int done_len [64];
    int uf_cnt = 0;
    int f_start = 0;
    logic [LANES-1:0] keeps [16];
    int acc [16];

    line_pace_sink #(
        .DATA_W    (DATA_W),
        .GAP_BYTES (GAP_BYTES),
        .FRAC_W    (FRAC_W),
        .INC_Q     (INC_Q),
        .LEN_W     (LEN_W),
        .TS_W      (TS_W)
    ) i_line_pace_sink (
        .clk       (clk),
        .rst       (rst),
        .s_tkeep   (tkeep),
        .s_tlast   (tlast),
        .s_tvalid  (tvalid),
        .s_tready  (tready),
        .ptp_now   (ptp),
        .ts_out    (ts),
        .ts_valid  (tsv),
        .frm_len   (flen),
        .frm_done  (fdone),
        .underflow (uflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc++;

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: sample outputs away from the edge, then advance the time source
    always @(negedge clk) begin
        if (!rst) begin
            if (tsv) begin
                chk("R5 captured time", ts, ptp);
                if (ts_cnt < 64) ts_edge[ts_cnt] = cyc;
                ts_cnt++;
            end
            if (fdone) begin
                if (done_cnt < 64) begin
                    done_edge[done_cnt] = cyc;
                    done_len[done_cnt]  = int'(flen);
                end
                done_cnt++;
            end
            if (uflow) uf_cnt++;
        end
        ptp = ptp + 96'd7;
    end

    task automatic send_frame(input int n, input int stall_at, input int stall_len, input bit hold);
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) begin
                tvalid = 1'b0;
                repeat (stall_len) @(negedge clk);
            end
            tkeep  = keeps[i];
            tlast  = (i == n - 1);
            tvalid = 1'b1;
            if (i == 0) f_start = cyc + 1;
            while (!tready) @(negedge clk);
            acc[i] = cyc + 1;
            @(negedge clk);
        end
        if (!hold) begin
            tvalid = 1'b0;
            tlast  = 1'b0;
        end
    endtask

    task automatic settle();
        tvalid = 1'b0;
        tlast  = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R1 ready in reset", tready, 0);
        chk("R1 ts strobe in reset", tsv, 0);
        chk("R1 done in reset", fdone, 0);
        chk("R1 underflow in reset", uflow, 0);
        chk("R1 ts in reset", ts, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_full_frame();
        int t0, d0, u0;
        t0 = ts_cnt; d0 = done_cnt; u0 = uf_cnt;
        for (int i = 0; i < 4; i++) keeps[i] = 8'hFF;
        send_frame(4, -1, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R5 one stamp per frame", ts_cnt - t0, 1);
        chk("R4 preamble length", ts_edge[t0] - f_start, 5);
        chk("R2 first accept after stamp", acc[0] - ts_edge[t0], 4);
        chk("R3 full beat spacing a", acc[1] - acc[0], 4);
        chk("R3 full beat spacing b", acc[3] - acc[2], 4);
        chk("R7 one done strobe", done_cnt - d0, 1);
        chk("R7 done timing", done_edge[d0] - acc[3], 0);
        chk("R7 full frame length", done_len[d0], 32);
        chk("R9 no underflow when fed", uf_cnt - u0, 0);
        settle();
    endtask

    task automatic t_partial_beats();
        int d0;
        d0 = done_cnt;
        keeps[0] = 8'h0F; keeps[1] = 8'hFF; keeps[2] = 8'h01;
        send_frame(3, -1, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R6 half beat cost", acc[1] - acc[0], 2);
        chk("R6 full beat after half", acc[2] - acc[1], 4);
        chk("R7 partial length", done_len[d0], 13);
        settle();
    endtask

    task automatic t_sparse_lanes();
        int d0;
        d0 = done_cnt;
        keeps[0] = 8'hAA; keeps[1] = 8'h81;
        send_frame(2, -1, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R6 sparse lane cost", acc[1] - acc[0], 2);
        chk("R7 sparse length", done_len[d0], 6);
        settle();
    endtask

    task automatic t_gap(input logic [LANES-1:0] last_keep, input int exp_edges, input int exp_len);
        int t0, d0, e_last;
        t0 = ts_cnt; d0 = done_cnt;
        keeps[0] = 8'hFF; keeps[1] = last_keep;
        send_frame(2, -1, 0, 1'b1);
        e_last = acc[1];
        keeps[0] = 8'hFF;
        send_frame(1, -1, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R8 stamps for two frames", ts_cnt - t0, 2);
        chk("R8 gap to next stamp", ts_edge[t0 + 1] - e_last, exp_edges);
        chk("R7 first of pair length", done_len[d0], exp_len);
        chk("R7 second of pair length", done_len[d0 + 1], 8);
        settle();
    endtask

    task automatic t_underflow();
        int d0, u0;
        d0 = done_cnt; u0 = uf_cnt;
        for (int i = 0; i < 3; i++) keeps[i] = 8'hFF;
        send_frame(3, 1, 6, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 stall flagged", (uf_cnt - u0) != 0, 1);
        chk("R7 length after stall", done_len[d0], 24);
        settle();
    endtask

    task automatic t_reset_clears();
        chk("R1 stamp held before reset", ts != 0, 1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 stamp wiped", ts, 0);
        chk("R1 strobe low", tsv, 0);
        chk("R1 ready low", tready, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        ptp = 96'h0000_00A5_0000_0001_0000_0100;
        t_reset();
        t_full_frame();
        t_partial_beats();
        t_sparse_lanes();
        t_gap(8'hFF, 12, 16);
        t_gap(8'h0F, 10, 12);
        t_underflow();
        t_reset_clears();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule